// File: doc/BRIEF.md
# Home Directory Line-Ownership Controller

This block is the home-node controller for a small, fixed group of cache lines. It holds one ownership state per line: exclusive, owner or not-owner, plus a set of transient busy states. It takes messages from three inbound channels, each with a valid/ready handshake:
- read-shared, read-exclusive and put requests from caches;
- unblock and writeback-completion messages;
- read-data and write-acknowledge responses from memory.

It produces three outbound streams: messages to peer caches, data responses to requesters, and read or write requests to memory.

A line that the home still owns answers a read by fetching from memory. The read is also broadcast to every peer except the requester. The fetch then completes in two independent halves: memory data, which produces the data response, and the requester's unblock. These two may land in either order. A line that the home does not own only broadcasts the request and waits for the unblock. A put is accepted only from the not-owner state, and it is settled by one of five writeback messages. While a line is busy, requests to it are held off at the channel until a message on another channel moves the line back to a stable state. Any message that does not fit the line's state sets a sticky error flag.

Top module: `dirctl_home`

## Requirements
- R1: After reset every line is exclusive, `err` is 0 and `mreq_valid`, `rsp_valid` and `fwd_valid` are 0. A put (`req_type`=2) to any line is then answered with `fwd_kind`=3 (refuse).
- R2: A read-shared (`req_type`=0) or read-exclusive (`req_type`=1) to an exclusive line does three things:
  - it issues a memory read (`mreq_wr`=0) naming the line and the requester;
  - it sends `fwd_kind` equal to `req_type`, with `fwd_dest` set to all caches except the requester (when `NUM_CACHES` > 1);
  - it leaves the line busy with a pending fetch whose later data response has `rsp_excl`=1.
- R3: On an owner line, a read-shared or read-exclusive fetches and forwards as in R2, with `rsp_excl`=0. After a read-shared the line settles back to owner. After a read-exclusive it settles to not-owner.
- R4: On a not-owner line, a read-shared or read-exclusive only forwards; no memory request is made. The line is busy until an unblock (`ub_type`=0) returns it to not-owner.
- R5: A put to a not-owner line sends `fwd_kind`=2 (accept) to the requester alone (`fwd_dest` one-hot) and the line enters writeback. A put to an owner or exclusive line sends `fwd_kind`=3 and leaves the state unchanged.
- R6: While a line is busy, `req_ready` is 0 for requests to it, the request is not consumed, and no output results.
- R7: In a pending fetch, memory data (`mr_type`=0) and unblock may arrive in either order.
  - If data comes first, one data response is sent, carrying the memory data, the recorded type and the requester as `rsp_dest`.
  - If the unblock comes first, the later data produces no response.
  - Either way, the line ends as not-owner, or as owner for an owner-side read-shared.
- R8: In writeback, a dirty writeback (`ub_type`=2) or exclusive-dirty writeback (`ub_type`=4) issues a memory write carrying `ub_data`. The following write acknowledge (`mr_type`=1) makes the line exclusive after type 2, and owner after type 4.
- R9: In writeback, a clean writeback (`ub_type`=1) makes the line owner, an exclusive-clean writeback (`ub_type`=3) makes it exclusive, and an unblock makes it not-owner.
- R10: At most one message is consumed per cycle. Memory responses take priority over the unblock channel, which takes priority over requests; `mr_ready` is always 1.
- R11: Memory requests and data responses appear one cycle after the message is accepted. Peer-cache messages appear `FWD_LAT` cycles after.
- R12: Three kinds of message set `err`, which stays 1 until reset:
  - an undefined type code (`req_type`=3, `ub_type`>4);
  - a memory response to a line with nothing outstanding;
  - an unblock-channel message that does not match the line's state.
  
  Such a message is consumed and leaves the line's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_type | input | 2 | 0 read-shared, 1 read-exclusive, 2 put |
| req_line | input | LW | Target line |
| req_src | input | SW | Requesting cache |
| ub_valid | input | 1 | Unblock/writeback message present |
| ub_ready | output | 1 | Unblock/writeback message accepted |
| ub_type | input | 3 | 0 unblock, 1 clean, 2 dirty, 3 excl-clean, 4 excl-dirty |
| ub_line | input | LW | Target line |
| ub_data | input | DW | Writeback data |
| mr_valid | input | 1 | Memory response present |
| mr_ready | output | 1 | Memory response accepted |
| mr_type | input | 1 | 0 read data, 1 write acknowledge |
| mr_line | input | LW | Target line |
| mr_data | input | DW | Read data |
| mreq_valid | output | 1 | Memory request |
| mreq_wr | output | 1 | 1 write, 0 read |
| mreq_line | output | LW | Line of the memory request |
| mreq_src | output | SW | Original requester (reads) |
| mreq_data | output | DW | Write data |
| rsp_valid | output | 1 | Data response |
| rsp_excl | output | 1 | 1 exclusive data, 0 shared data |
| rsp_line | output | LW | Line of the response |
| rsp_dest | output | SW | Destination cache |
| rsp_data | output | DW | Response data |
| fwd_valid | output | 1 | Peer-cache message |
| fwd_kind | output | 2 | 0 fwd read-shared, 1 fwd read-exclusive, 2 accept, 3 refuse |
| fwd_line | output | LW | Line of the message |
| fwd_src | output | SW | Original requester |
| fwd_dest | output | NUM_CACHES | Destination mask |
| err | output | 1 | Sticky protocol error |

## Verification
The two halves of a pending fetch can be offered in the same cycle: memory data for the line on the memory channel and an unblock for it on the unblock channel. The bench drives both together on a line whose fetch is pending. It expects the memory channel to win: the unblock must see `ub_ready` low while the data response appears in the next cycle. The unblock is then accepted one cycle later. The line must end in the correct stable state, which a following put shows through accept or refuse. Random traffic covers both arrival orders separately and compares every output against a model kept in the bench.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;

  typedef enum logic [3:0] {
    ST_EXCL, ST_OWN, ST_NOWN,
    ST_NOWN_BLK, ST_OWN_BLK,
    ST_NOWN_BLK_MEM, ST_OWN_BLK_MEM,
    ST_NOWN_MEM, ST_OWN_MEM,
    ST_WBK, ST_WBK_TO_OWN, ST_WBK_TO_EXCL
  } line_st_t;

  typedef enum logic [3:0] {
    EV_NONE, EV_GETS, EV_GETX, EV_PUT, EV_UNBLOCK,
    EV_WB_CLEAN, EV_WB_DIRTY, EV_WB_XCLEAN, EV_WB_XDIRTY,
    EV_MDATA, EV_MACK, EV_BAD
  } ev_t;

  typedef enum logic [1:0] {FW_GETS, FW_GETX, FW_ACK, FW_NACK} fwd_kind_t;

  typedef struct packed {
    logic legal;
    logic fetch;
    logic fwd;
    logic ack;
    logic nack;
    logic send;
    logic memwr;
    logic alloc;
    logic rec_excl;
    logic free;
  } act_t;

  function automatic logic st_busy(line_st_t s);
    return !(s inside {ST_EXCL, ST_OWN, ST_NOWN});
  endfunction

  function automatic logic st_fetching(line_st_t s);
    return s inside {ST_NOWN_BLK_MEM, ST_OWN_BLK_MEM, ST_NOWN_MEM, ST_OWN_MEM};
  endfunction

endpackage

// File: rtl/dirctl_decode.sv
module dirctl_decode
  import dirctl_pkg::*;
(
  input  logic       use_req,
  input  logic       use_ub,
  input  logic       use_mr,
  input  logic [1:0] req_type,
  input  logic [2:0] ub_type,
  input  logic       mr_type,
  output ev_t        ev
);
  always_comb begin
    ev = EV_NONE;
    if (use_mr) begin
      ev = mr_type ? EV_MACK : EV_MDATA;
    end else if (use_ub) begin
      case (ub_type)
        3'd0:    ev = EV_UNBLOCK;
        3'd1:    ev = EV_WB_CLEAN;
        3'd2:    ev = EV_WB_DIRTY;
        3'd3:    ev = EV_WB_XCLEAN;
        3'd4:    ev = EV_WB_XDIRTY;
        default: ev = EV_BAD;
      endcase
    end else if (use_req) begin
      case (req_type)
        2'd0:    ev = EV_GETS;
        2'd1:    ev = EV_GETX;
        2'd2:    ev = EV_PUT;
        default: ev = EV_BAD;
      endcase
    end
  end
endmodule

// File: rtl/dirctl_transition.sv
module dirctl_transition
  import dirctl_pkg::*;
(
  input  line_st_t cur,
  input  ev_t      ev,
  output line_st_t nxt,
  output act_t     act
);
  always_comb begin
    nxt = cur;
    act = '0;
    act.legal = 1'b1;
    if (ev != EV_NONE) begin
      act.legal = 1'b0;
      unique case (cur)
        ST_EXCL, ST_OWN: begin
          if (ev == EV_GETS || ev == EV_GETX) begin
            act.legal    = 1'b1;
            act.fetch    = 1'b1;
            act.fwd      = 1'b1;
            act.alloc    = 1'b1;
            act.rec_excl = (cur == ST_EXCL);
            nxt = (cur == ST_OWN && ev == EV_GETS) ? ST_OWN_BLK_MEM : ST_NOWN_BLK_MEM;
          end else if (ev == EV_PUT) begin
            act.legal = 1'b1;
            act.nack  = 1'b1;
          end
        end
        ST_NOWN: begin
          if (ev == EV_GETS || ev == EV_GETX) begin
            act.legal = 1'b1;
            act.fwd   = 1'b1;
            nxt = ST_NOWN_BLK;
          end else if (ev == EV_PUT) begin
            act.legal = 1'b1;
            act.ack   = 1'b1;
            nxt = ST_WBK;
          end
        end
        ST_NOWN_BLK, ST_OWN_BLK: begin
          if (ev == EV_UNBLOCK) begin
            act.legal = 1'b1;
            nxt = (cur == ST_OWN_BLK) ? ST_OWN : ST_NOWN;
          end
        end
        ST_NOWN_BLK_MEM, ST_OWN_BLK_MEM: begin
          if (ev == EV_MDATA) begin
            act.legal = 1'b1;
            act.send  = 1'b1;
            act.free  = 1'b1;
            nxt = (cur == ST_OWN_BLK_MEM) ? ST_OWN_BLK : ST_NOWN_BLK;
          end else if (ev == EV_UNBLOCK) begin
            act.legal = 1'b1;
            nxt = (cur == ST_OWN_BLK_MEM) ? ST_OWN_MEM : ST_NOWN_MEM;
          end
        end
        ST_NOWN_MEM, ST_OWN_MEM: begin
          if (ev == EV_MDATA) begin
            act.legal = 1'b1;
            act.free  = 1'b1;
            nxt = (cur == ST_OWN_MEM) ? ST_OWN : ST_NOWN;
          end
        end
        ST_WBK: begin
          act.legal = 1'b1;
          case (ev)
            EV_WB_DIRTY:  begin act.memwr = 1'b1; nxt = ST_WBK_TO_EXCL; end
            EV_WB_XDIRTY: begin act.memwr = 1'b1; nxt = ST_WBK_TO_OWN;  end
            EV_WB_CLEAN:  nxt = ST_OWN;
            EV_WB_XCLEAN: nxt = ST_EXCL;
            EV_UNBLOCK:   nxt = ST_NOWN;
            default:      act.legal = 1'b0;
          endcase
        end
        ST_WBK_TO_EXCL, ST_WBK_TO_OWN: begin
          if (ev == EV_MACK) begin
            act.legal = 1'b1;
            nxt = (cur == ST_WBK_TO_OWN) ? ST_OWN : ST_EXCL;
          end
        end
        default: act.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dirctl_fwd_pipe.sv
module dirctl_fwd_pipe #(
  parameter int DEPTH = 3,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic [DEPTH-1:0] v;
  logic [W-1:0]     d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic         pv;
    logic [W-1:0] pd;
    if (i == 0) begin : g_head
      assign pv = in_valid;
      assign pd = in_data;
    end else begin : g_body
      assign pv = v[i-1];
      assign pd = d[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst) v[i] <= 1'b0;
      else     v[i] <= pv;
      d[i] <= pd;
    end
  end

  assign out_valid = v[DEPTH-1];
  assign out_data  = d[DEPTH-1];

  a_r11_pipe_delay: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> v[0]);
endmodule

// File: rtl/dirctl_home.sv
module dirctl_home
  import dirctl_pkg::*;
#(
  parameter int NLINES     = 4,
  parameter int NUM_CACHES = 4,
  parameter int DW         = 32,
  parameter int FWD_LAT    = 3,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int SW = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_type,
  input  logic [LW-1:0]         req_line,
  input  logic [SW-1:0]         req_src,
  input  logic                  ub_valid,
  output logic                  ub_ready,
  input  logic [2:0]            ub_type,
  input  logic [LW-1:0]         ub_line,
  input  logic [DW-1:0]         ub_data,
  input  logic                  mr_valid,
  output logic                  mr_ready,
  input  logic                  mr_type,
  input  logic [LW-1:0]         mr_line,
  input  logic [DW-1:0]         mr_data,
  output logic                  mreq_valid,
  output logic                  mreq_wr,
  output logic [LW-1:0]         mreq_line,
  output logic [SW-1:0]         mreq_src,
  output logic [DW-1:0]         mreq_data,
  output logic                  rsp_valid,
  output logic                  rsp_excl,
  output logic [LW-1:0]         rsp_line,
  output logic [SW-1:0]         rsp_dest,
  output logic [DW-1:0]         rsp_data,
  output logic                  fwd_valid,
  output logic [1:0]            fwd_kind,
  output logic [LW-1:0]         fwd_line,
  output logic [SW-1:0]         fwd_src,
  output logic [NUM_CACHES-1:0] fwd_dest,
  output logic                  err
);
  localparam bit FWD_ON = (NUM_CACHES > 1);
  localparam int PW     = 2 + LW + SW + NUM_CACHES;
  localparam logic [NUM_CACHES-1:0] ALL_CACHES = {NUM_CACHES{1'b1}};

  line_st_t           lst   [NLINES];
  logic [NLINES-1:0]  trk_v;
  logic [NLINES-1:0]  trk_x;
  logic [SW-1:0]      trk_r [NLINES];

  logic     use_req, use_ub, use_mr;
  logic [LW-1:0] cur_line;
  ev_t      ev;
  line_st_t cur_st, nxt_st;
  act_t     act;
  logic     do_step;

  // channel arbitration: memory, then unblock, then requests to idle lines
  always_comb begin
    use_mr  = mr_valid;
    use_ub  = !mr_valid && ub_valid;
    use_req = !mr_valid && !ub_valid && req_valid && !st_busy(lst[req_line]);
    cur_line = use_mr ? mr_line : (use_ub ? ub_line : req_line);
    cur_st   = lst[cur_line];
  end

  assign mr_ready  = 1'b1;
  assign ub_ready  = !mr_valid;
  assign req_ready = !mr_valid && !ub_valid && !st_busy(lst[req_line]);

  dirctl_decode u_decode (
    .use_req (use_req),
    .use_ub  (use_ub),
    .use_mr  (use_mr),
    .req_type(req_type),
    .ub_type (ub_type),
    .mr_type (mr_type),
    .ev      (ev)
  );

  dirctl_transition u_trans (
    .cur(cur_st),
    .ev (ev),
    .nxt(nxt_st),
    .act(act)
  );

  assign do_step = (ev != EV_NONE) && act.legal;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        lst[i]   <= ST_EXCL;
        trk_v[i] <= 1'b0;
        trk_x[i] <= 1'b0;
        trk_r[i] <= '0;
      end else if (do_step && cur_line == LW'(i)) begin
        lst[i] <= nxt_st;
        if (act.alloc) begin
          trk_v[i] <= 1'b1;
          trk_x[i] <= act.rec_excl;
          trk_r[i] <= req_src;
        end else if (act.free) begin
          trk_v[i] <= 1'b0;
        end
      end
    end

    a_r7_track_matches_state: assert property (@(posedge clk) disable iff (rst)
      trk_v[i] == st_fetching(lst[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else if (ev != EV_NONE && !act.legal) err <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mreq_valid <= 1'b0;
      rsp_valid  <= 1'b0;
    end else begin
      mreq_valid <= do_step && (act.fetch || act.memwr);
      rsp_valid  <= do_step && act.send;
    end
    mreq_wr   <= act.memwr;
    mreq_line <= cur_line;
    mreq_src  <= req_src;
    mreq_data <= act.memwr ? ub_data : '0;
    rsp_excl  <= trk_x[cur_line];
    rsp_dest  <= trk_r[cur_line];
    rsp_line  <= cur_line;
    rsp_data  <= mr_data;
  end

  // peer-cache stream through a fixed-latency delay line
  logic                  fin_valid;
  fwd_kind_t             fin_kind;
  logic [NUM_CACHES-1:0] fin_dest;
  logic [NUM_CACHES-1:0] src_hot;
  logic [PW-1:0]         fout;

  always_comb begin
    src_hot   = NUM_CACHES'(1) << req_src;
    fin_valid = do_step && ((act.fwd && FWD_ON) || act.ack || act.nack);
    if (act.ack)       fin_kind = FW_ACK;
    else if (act.nack) fin_kind = FW_NACK;
    else               fin_kind = (ev == EV_GETX) ? FW_GETX : FW_GETS;
    fin_dest = (act.ack || act.nack) ? src_hot : (ALL_CACHES & ~src_hot);
  end

  dirctl_fwd_pipe #(.DEPTH(FWD_LAT), .W(PW)) u_fwd_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_valid (fin_valid),
    .in_data  ({fin_kind, cur_line, req_src, fin_dest}),
    .out_valid(fwd_valid),
    .out_data (fout)
  );

  assign {fwd_kind, fwd_line, fwd_src, fwd_dest} = fout;

  a_r10_one_accept: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_valid && req_ready, ub_valid && ub_ready, mr_valid && mr_ready}));

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  a_r11_rsp_after_data: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(mr_valid && !mr_type));

  a_r2_fetch_tracked: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && !mreq_wr) |-> trk_v[mreq_line]);

endmodule

// File: tb/test_dirctl_home.sv
`timescale 1ns/1ps
module test_dirctl_home;
  localparam int NL = 4;
  localparam int NC = 4;
  localparam int DW = 32;
  localparam int FL = 3;
  localparam int LW = 2;
  localparam int SW = 2;

  localparam int M_E = 0, M_O = 1, M_NO = 2, M_NOB = 3, M_OB = 4, M_NOBW = 5,
                 M_OBW = 6, M_NOW = 7, M_OW = 8, M_WB = 9, M_WBO = 10, M_WBE = 11;

  logic clk = 0, rst = 1;
  logic req_valid = 0, ub_valid = 0, mr_valid = 0;
  logic [1:0] req_type = 0; logic [LW-1:0] req_line = 0; logic [SW-1:0] req_src = 0;
  logic [2:0] ub_type = 0;  logic [LW-1:0] ub_line = 0;  logic [DW-1:0] ub_data = 0;
  logic mr_type = 0;        logic [LW-1:0] mr_line = 0;  logic [DW-1:0] mr_data = 0;
  logic req_ready, ub_ready, mr_ready;
  logic mreq_valid, mreq_wr; logic [LW-1:0] mreq_line; logic [SW-1:0] mreq_src; logic [DW-1:0] mreq_data;
  logic rsp_valid, rsp_excl; logic [LW-1:0] rsp_line; logic [SW-1:0] rsp_dest; logic [DW-1:0] rsp_data;
  logic fwd_valid; logic [1:0] fwd_kind; logic [LW-1:0] fwd_line; logic [SW-1:0] fwd_src;
  logic [NC-1:0] fwd_dest; logic err;

  always #4 clk = ~clk;

  dirctl_home #(.NLINES(NL), .NUM_CACHES(NC), .DW(DW), .FWD_LAT(FL)) i_dirctl_home (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int ms [NL]; int mx [NL]; int mq [NL]; int merr = 0;
  int n_f, n_m, n_r, f_at, m_at, r_at;
  int c_fk, c_fd, c_fl, c_fs, c_mw, c_ml, c_ms, c_rx, c_rd, c_rl;
  logic [DW-1:0] c_md, c_rdat;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (fwd_valid) begin n_f++; f_at = cyc; c_fk = fwd_kind; c_fd = fwd_dest; c_fl = fwd_line; c_fs = fwd_src; end
    if (mreq_valid) begin n_m++; m_at = cyc; c_mw = mreq_wr; c_ml = mreq_line; c_ms = mreq_src; c_md = mreq_data; end
    if (rsp_valid) begin n_r++; r_at = cyc; c_rx = rsp_excl; c_rd = rsp_dest; c_rl = rsp_line; c_rdat = rsp_data; end
  end

  task automatic eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit stable(int s);
    return s == M_E || s == M_O || s == M_NO;
  endfunction

  task automatic clr();
    n_f = 0; n_m = 0; n_r = 0;
  endtask

  // send one message on channel ch (0 request, 1 unblock/writeback, 2 memory) and check all outputs
  task automatic deliver(input int ch, input int typ, input int line, input int src, input logic [DW-1:0] data);
    int s, ns, c0, ef, ek, ed, em, ewr, er, ex;
    string tag;
    logic rdy;
    s = ms[line]; ns = s; ef = 0; ek = 0; ed = 0; em = 0; ewr = 0; er = 0; ex = 0; tag = "R12";
    clr();
    case (ch)
      0: begin req_valid = 1; req_type = 2'(typ); req_line = LW'(line); req_src = SW'(src); end
      1: begin ub_valid = 1; ub_type = 3'(typ); ub_line = LW'(line); ub_data = data; end
      default: begin mr_valid = 1; mr_type = typ[0]; mr_line = LW'(line); mr_data = data; end
    endcase
    #1;
    rdy = (ch == 0) ? req_ready : (ch == 1) ? ub_ready : mr_ready;
    eq("R10 ready", rdy, 1);
    c0 = cyc;
    @(posedge clk); @(negedge clk);
    req_valid = 0; ub_valid = 0; mr_valid = 0;
    repeat (FL) @(negedge clk);
    #1;
    if (ch == 0 && typ == 2 && stable(s)) begin
      ef = 1; ed = 1 << src;
      if (s == M_NO) begin ek = 2; ns = M_WB; tag = "R5"; end
      else begin ek = 3; tag = "R5"; end
    end else if (ch == 0 && typ < 2 && stable(s)) begin
      ef = 1; ek = typ; ed = ((1 << NC) - 1) & ~(1 << src);
      if (s == M_NO) begin ns = M_NOB; tag = "R4"; end
      else begin
        em = 1; mx[line] = (s == M_E); mq[line] = src; ex = mx[line];
        ns = (s == M_O && typ == 0) ? M_OBW : M_NOBW;
        tag = (s == M_E) ? "R2" : "R3";
      end
    end else if (ch == 1) begin
      if (typ == 0 && (s == M_NOB || s == M_OB)) begin ns = (s == M_OB) ? M_O : M_NO; tag = "R4"; end
      else if (typ == 0 && (s == M_NOBW || s == M_OBW)) begin ns = (s == M_OBW) ? M_OW : M_NOW; tag = "R7"; end
      else if (s == M_WB && typ <= 4) begin
        tag = "R9";
        case (typ)
          0: ns = M_NO;
          1: ns = M_O;
          3: ns = M_E;
          2: begin ns = M_WBE; em = 1; ewr = 1; tag = "R8"; end
          default: begin ns = M_WBO; em = 1; ewr = 1; tag = "R8"; end
        endcase
      end else merr = 1;
    end else if (ch == 2) begin
      if (typ == 0 && (s == M_NOBW || s == M_OBW)) begin er = 1; ns = (s == M_OBW) ? M_OB : M_NOB; tag = "R7"; end
      else if (typ == 0 && (s == M_NOW || s == M_OW)) begin ns = (s == M_OW) ? M_O : M_NO; tag = "R7"; end
      else if (typ == 1 && (s == M_WBE || s == M_WBO)) begin ns = (s == M_WBO) ? M_O : M_E; tag = "R8"; end
      else merr = 1;
    end else merr = 1;
    ms[line] = ns;
    eq({tag, " fwd count"}, n_f, ef);
    if (ef && n_f == 1) begin
      eq({tag, " fwd kind"}, c_fk, ek);
      eq({tag, " fwd dest"}, c_fd, ed);
      eq({tag, " fwd line"}, c_fl, line);
      eq({tag, " fwd src"}, c_fs, src);
      eq("R11 fwd latency", f_at, c0 + FL);
    end
    eq({tag, " mem count"}, n_m, em);
    if (em && n_m == 1) begin
      eq({tag, " mem wr"}, c_mw, ewr);
      eq({tag, " mem line"}, c_ml, line);
      if (ewr) eq({tag, " mem data"}, c_md, data);
      else     eq({tag, " mem src"}, c_ms, src);
      eq("R11 mem latency", m_at, c0 + 1);
    end
    eq({tag, " rsp count"}, n_r, er);
    if (er && n_r == 1) begin
      eq({tag, " rsp excl"}, c_rx, mx[line]);
      eq({tag, " rsp dest"}, c_rd, mq[line]);
      eq({tag, " rsp data"}, c_rdat, data);
      eq({tag, " rsp line"}, c_rl, line);
      eq("R11 rsp latency", r_at, c0 + 1);
    end
    eq("R12 err", err, merr);
  endtask

  // offer a request to a busy line and expect it to be held
  task automatic probe_blocked(input int line);
    clr();
    req_valid = 1; req_type = 2'($urandom % 3); req_line = LW'(line); req_src = SW'($urandom % NC);
    #1; eq("R6 ready low", req_ready, 0);
    repeat (2) @(negedge clk);
    req_valid = 0;
    repeat (FL) @(negedge clk);
    eq("R6 no output", n_f + n_m + n_r, 0);
  endtask

  task automatic step(input int line, input bit allow_req);
    int s;
    s = ms[line];
    if (stable(s)) begin
      if (allow_req) deliver(0, $urandom % 3, line, $urandom % NC, 0);
    end else begin
      if ($urandom % 4 == 0 && allow_req) probe_blocked(line);
      case (s)
        M_NOB, M_OB: deliver(1, 0, line, 0, 0);
        M_NOBW, M_OBW: if ($urandom % 2) deliver(2, 0, line, 0, $urandom);
                       else deliver(1, 0, line, 0, 0);
        M_NOW, M_OW: deliver(2, 0, line, 0, $urandom);
        M_WB: deliver(1, $urandom % 5, line, 0, $urandom);
        default: deliver(2, 1, line, 0, 0);
      endcase
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NL; i++) begin ms[i] = M_E; mx[i] = 0; mq[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    eq("R1 err", err, 0);
    eq("R1 mreq_valid", mreq_valid, 0);
    eq("R1 rsp_valid", rsp_valid, 0);
    eq("R1 fwd_valid", fwd_valid, 0);
    eq("R10 mr_ready", mr_ready, 1);
    for (int l = 0; l < NL; l++) begin
      deliver(0, 2, l, l % NC, 0);
      eq("R1 reset state refuses put", c_fk, 3);
    end

    // same-cycle memory data and unblock on a pending fetch (R7, R10)
    deliver(0, 1, 0, 1, 0);
    clr();
    mr_valid = 1; mr_type = 0; mr_line = 0; mr_data = 32'hCAFE_0001;
    ub_valid = 1; ub_type = 0; ub_line = 0;
    #1;
    eq("R10 ub held", ub_ready, 0);
    @(posedge clk); @(negedge clk);
    mr_valid = 0;
    eq("R7 rsp on data first", rsp_valid, 1);
    eq("R7 rsp data", rsp_data, 32'hCAFE_0001);
    eq("R7 rsp excl", rsp_excl, 1);
    #1; eq("R10 ub now ready", ub_ready, 1);
    @(posedge clk); @(negedge clk);
    ub_valid = 0;
    repeat (FL) @(negedge clk);
    ms[0] = M_NO;
    deliver(0, 2, 0, 2, 0);
    eq("R7 ends not-owner", c_fk, 2);
    deliver(1, 4, 0, 0, 32'h1234_5678);
    deliver(2, 1, 0, 0, 0);

    for (int it = 0; it < 400; it++) step($urandom % NL, 1'b1);
    for (int l = 0; l < NL; l++) while (!stable(ms[l])) step(l, 1'b0);

    // protocol errors (R12)
    deliver(2, 1, 1, 0, 0);
    eq("R12 stray ack sets err", err, 1);
    deliver(0, 2, 1, 1, 0);
    deliver(1, 6, 2, 0, 0);
    deliver(0, 3, 3, 0, 0);
    eq("R12 err stays", err, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule